// File: doc/BRIEF.md
# Scalar Ladder Micro-Operation Sequencer

This block is the control half of a fixed-base point multiplier on a twisted Edwards curve. It is given a 256-bit scalar and a start strobe. It clamps the scalar and walks a two-register ladder through all 256 scalar bits. The walk is expressed as a stream of field micro-operations (move, add, subtract, multiply, invert). These go to a field-arithmetic engine outside the block, one at a time, through a request/done handshake. The engine owns a flat slot file of operands. The sequencer only names slots: two sources and two destinations per operation.

For each scalar bit, the sequencer copies the two ladder points into working points U and V, choosing the order by the bit. It doubles U into S, then adds V to S into T, and writes T back over one of the ladder points. After the last bit, it moves the Z coordinate of the first ladder point into the inversion input slot and issues one inversion request. It then signals completion with a one-cycle pulse.

Top module: `ladder_seq`

## Requirements
- R1: On an accepted start the scalar is captured with its bits 0, 1 and 2 forced to zero. Only the clamped value steers the ladder.
- R2: The captured scalar has bit 255 forced to zero and bit 254 forced to one.
- R3: Scalar bits are consumed in ascending index order, bit 0 first (word 0 bit 0 up to word 7 bit 31), giving exactly 256 ladder iterations of 42 operations each.
- R4: Slot map: ZERO=0, ONE=1, GX=2, GY=3, GT=4, P0 X/Y/Z/T=5..8, P1 X/Y/Z/T=9..12, S=13..16, T=17..20, U=21..24, V=25..28, work slots A..J=29..38, inversion input=39. The run opens with 8 moves in this order: ZERO,ONE,ONE,ZERO into P0 X,Y,Z,T, then GX,GY,ONE,GT into P1 X,Y,Z,T.
- R5: Each iteration starts with 8 single moves. The sources are P0 X..T, then P1 X..T. When the bit is 1, P0 goes to U and P1 to V. When it is 0, P0 goes to V and P1 to U. The coordinate offset is kept. A single move has src_b equal to src_a and dst_b equal to dst_a.
- R6: Opcodes: MOVE=0, ADD=1, SUB=2, MUL=3, INV=4. Operations 8..39 of an iteration are a fixed list of 32 arithmetic steps, with dst_b equal to dst_a. Steps 8..21 double U into S and steps 22..39 add S and V into T, as listed in the notes of the bench.
- R7: Operations 40 and 41 are double moves (T.X,T.Y) and (T.Z,T.T). They go into P0 when the bit is 1 and into P1 when it is 0, with src_a to dst_a and src_b to dst_b.
- R8: After the last iteration, exactly two operations follow: MOVE of P0.Z (slot 7) into slot 39, then INV with all four operand fields equal to 39.
- R9: An operation is complete only in a cycle with req and done both high. Until then req stays high and the opcode and all four slot fields hold still.
- R10: busy rises the cycle after an accepted start and falls in the cycle after the INV completes. In that same cycle ready is high for exactly one cycle, and it is otherwise low.
- R11: start is ignored while busy or ready is high, and the scalar input is then ignored as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| scalar | input | 256 | Scalar, sampled on an accepted start |
| busy | output | 1 | Run in progress |
| ready | output | 1 | One-cycle completion pulse |
| uop_req | output | 1 | Operation request |
| uop_code | output | 3 | Opcode |
| uop_src_a | output | 6 | First source slot |
| uop_src_b | output | 6 | Second source slot |
| uop_dst_a | output | 6 | First destination slot |
| uop_dst_b | output | 6 | Second destination slot |
| uop_done | input | 1 | Engine completes the current request |

## Verification
The first request appears one cycle after the accepting start edge, and each later request appears in the cycle right after the done of the one before. busy follows the start by one cycle, and ready and the busy fall follow the INV completion by one cycle. The bench model keeps the expected values for busy and ready one cycle ahead. On every falling edge it compares them with the outputs, and it checks each operation against a queue in the cycle where req and done meet. The stub engine varies its latency between one and two cycles, so back-to-back and waiting requests both occur.

// File: rtl/ladder_pkg.sv
package ladder_pkg;
   localparam int SLOT_W = 6;
   typedef logic [SLOT_W-1:0] slot_t;

   typedef enum logic [2:0] {
      OP_MOVE = 3'd0,
      OP_ADD  = 3'd1,
      OP_SUB  = 3'd2,
      OP_MUL  = 3'd3,
      OP_INV  = 3'd4
   } opcode_e;

   typedef enum logic [2:0] {
      PH_IDLE, PH_INIT, PH_LOOP, PH_FIN, PH_DONE
   } phase_e;

   typedef struct packed {
      opcode_e code;
      slot_t   a;
      slot_t   b;
      slot_t   d;
      slot_t   d2;
   } uop_t;

   localparam slot_t S_ZERO = 6'd0;
   localparam slot_t S_ONE  = 6'd1;
   localparam slot_t S_GX   = 6'd2;
   localparam slot_t S_GY   = 6'd3;
   localparam slot_t S_GT   = 6'd4;
   localparam slot_t S_P0   = 6'd5;
   localparam slot_t S_P1   = 6'd9;
   localparam slot_t S_SS   = 6'd13;
   localparam slot_t S_TT   = 6'd17;
   localparam slot_t S_UU   = 6'd21;
   localparam slot_t S_VV   = 6'd25;
   localparam slot_t W_A    = 6'd29;
   localparam slot_t W_B    = 6'd30;
   localparam slot_t W_C    = 6'd31;
   localparam slot_t W_D    = 6'd32;
   localparam slot_t W_E    = 6'd33;
   localparam slot_t W_F    = 6'd34;
   localparam slot_t W_G    = 6'd35;
   localparam slot_t W_H    = 6'd36;
   localparam slot_t W_I    = 6'd37;
   localparam slot_t W_J    = 6'd38;
   localparam slot_t S_INV  = 6'd39;

   localparam int INIT_LEN = 8;
   localparam int LOOP_LEN = 42;
   localparam int FIN_LEN  = 2;
endpackage

// File: rtl/ladder_key.sv
module ladder_key #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 8,
   parameter bit CLAMP_EN  = 1'b1,
   localparam int KEY_W = WORD_W * NUM_WORDS,
   localparam int BIT_W = $clog2(WORD_W),
   localparam int WRD_W = $clog2(NUM_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [KEY_W-1:0] key_in,
   output logic             key_bit,
   output logic             last_bit
);
   initial begin
      assert (KEY_W >= 8) else $error("key too narrow");
      assert (WORD_W == (1 << BIT_W)) else $error("WORD_W must be a power of two");
      assert (NUM_WORDS == (1 << WRD_W)) else $error("NUM_WORDS must be a power of two");
   end

   logic [KEY_W-1:0] clamped;
   logic [KEY_W-1:0] key_q;
   logic [BIT_W-1:0] bit_q;
   logic [WRD_W-1:0] wrd_q;

   generate
      if (CLAMP_EN) begin : g_clamp
         always_comb begin
            clamped            = key_in;
            clamped[2:0]       = 3'b000;
            clamped[KEY_W-1]   = 1'b0;
            clamped[KEY_W-2]   = 1'b1;
         end
      end else begin : g_raw
         assign clamped = key_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         bit_q <= '0;
         wrd_q <= '0;
      end else if (load) begin
         key_q <= clamped;
         bit_q <= '0;
         wrd_q <= '0;
      end else if (step) begin
         bit_q <= bit_q + 1'b1;
         if (bit_q == BIT_W'(WORD_W - 1))
            wrd_q <= wrd_q + 1'b1;
      end
   end

   logic [WORD_W-1:0] cur_word;
   assign cur_word = key_q[wrd_q*WORD_W +: WORD_W];
   assign key_bit  = cur_word[bit_q];
   assign last_bit = (bit_q == BIT_W'(WORD_W - 1)) && (wrd_q == WRD_W'(NUM_WORDS - 1));
endmodule

// File: rtl/ladder_urom.sv
module ladder_urom
   import ladder_pkg::*;
(
   input  phase_e     phase,
   input  logic [5:0] pc,
   input  logic       key_bit,
   output uop_t       uop
);
   function automatic uop_t mk(opcode_e c, slot_t a, slot_t b, slot_t d, slot_t d2);
      uop_t u;
      u.code = c; u.a = a; u.b = b; u.d = d; u.d2 = d2;
      return u;
   endfunction

   function automatic uop_t ar(opcode_e c, slot_t a, slot_t b, slot_t d);
      return mk(c, a, b, d, d);
   endfunction

   slot_t src_cp, dst_cp, cm_base;
   logic  from_p1;

   always_comb begin
      from_p1 = pc[2];
      src_cp  = (from_p1 ? S_P1 : S_P0) + slot_t'(pc[1:0]);
      dst_cp  = ((from_p1 ^ key_bit) ? S_UU : S_VV) + slot_t'(pc[1:0]);
      cm_base = key_bit ? S_P0 : S_P1;
   end

   always_comb begin
      uop = ar(OP_MOVE, S_ZERO, S_ZERO, S_ZERO);
      unique case (phase)
         PH_INIT: begin
            unique case (pc[2:0])
               3'd0: uop = ar(OP_MOVE, S_ZERO, S_ZERO, S_P0);
               3'd1: uop = ar(OP_MOVE, S_ONE,  S_ONE,  S_P0 + 6'd1);
               3'd2: uop = ar(OP_MOVE, S_ONE,  S_ONE,  S_P0 + 6'd2);
               3'd3: uop = ar(OP_MOVE, S_ZERO, S_ZERO, S_P0 + 6'd3);
               3'd4: uop = ar(OP_MOVE, S_GX,   S_GX,   S_P1);
               3'd5: uop = ar(OP_MOVE, S_GY,   S_GY,   S_P1 + 6'd1);
               3'd6: uop = ar(OP_MOVE, S_ONE,  S_ONE,  S_P1 + 6'd2);
               default: uop = ar(OP_MOVE, S_GT, S_GT,  S_P1 + 6'd3);
            endcase
         end
         PH_LOOP: begin
            if (pc < 6'd8) uop = ar(OP_MOVE, src_cp, src_cp, dst_cp);
            else begin
               unique case (pc)
                  // doubling U -> S
                  6'd8:  uop = ar(OP_MUL, S_UU,       S_UU,       W_A);
                  6'd9:  uop = ar(OP_MUL, S_UU + 6'd1, S_UU + 6'd1, W_B);
                  6'd10: uop = ar(OP_MUL, S_UU + 6'd2, S_UU + 6'd2, W_I);
                  6'd11: uop = ar(OP_ADD, W_I, W_I, W_C);
                  6'd12: uop = ar(OP_ADD, S_UU, S_UU + 6'd1, W_I);
                  6'd13: uop = ar(OP_MUL, W_I, W_I, W_D);
                  6'd14: uop = ar(OP_ADD, W_A, W_B, W_H);
                  6'd15: uop = ar(OP_SUB, W_H, W_D, W_E);
                  6'd16: uop = ar(OP_SUB, W_A, W_B, W_G);
                  6'd17: uop = ar(OP_ADD, W_C, W_G, W_F);
                  6'd18: uop = ar(OP_MUL, W_E, W_F, S_SS);
                  6'd19: uop = ar(OP_MUL, W_G, W_H, S_SS + 6'd1);
                  6'd20: uop = ar(OP_MUL, W_E, W_H, S_SS + 6'd3);
                  6'd21: uop = ar(OP_MUL, W_F, W_G, S_SS + 6'd2);
                  // addition S + V -> T
                  6'd22: uop = ar(OP_SUB, S_SS + 6'd1, S_SS, W_I);
                  6'd23: uop = ar(OP_ADD, S_VV + 6'd1, S_VV, W_J);
                  6'd24: uop = ar(OP_MUL, W_I, W_J, W_A);
                  6'd25: uop = ar(OP_ADD, S_SS + 6'd1, S_SS, W_I);
                  6'd26: uop = ar(OP_SUB, S_VV + 6'd1, S_VV, W_J);
                  6'd27: uop = ar(OP_MUL, W_I, W_J, W_B);
                  6'd28: uop = ar(OP_MUL, S_SS + 6'd2, S_VV + 6'd3, W_I);
                  6'd29: uop = ar(OP_ADD, W_I, W_I, W_C);
                  6'd30: uop = ar(OP_MUL, S_SS + 6'd3, S_VV + 6'd2, W_I);
                  6'd31: uop = ar(OP_ADD, W_I, W_I, W_D);
                  6'd32: uop = ar(OP_ADD, W_C, W_D, W_E);
                  6'd33: uop = ar(OP_SUB, W_B, W_A, W_F);
                  6'd34: uop = ar(OP_ADD, W_B, W_A, W_G);
                  6'd35: uop = ar(OP_SUB, W_D, W_C, W_H);
                  6'd36: uop = ar(OP_MUL, W_E, W_F, S_TT);
                  6'd37: uop = ar(OP_MUL, W_G, W_H, S_TT + 6'd1);
                  6'd38: uop = ar(OP_MUL, W_E, W_H, S_TT + 6'd3);
                  6'd39: uop = ar(OP_MUL, W_F, W_G, S_TT + 6'd2);
                  6'd40: uop = mk(OP_MOVE, S_TT, S_TT + 6'd1, cm_base, cm_base + 6'd1);
                  default: uop = mk(OP_MOVE, S_TT + 6'd2, S_TT + 6'd3, cm_base + 6'd2, cm_base + 6'd3);
               endcase
            end
         end
         PH_FIN: begin
            if (pc[0]) uop = ar(OP_INV, S_INV, S_INV, S_INV);
            else       uop = ar(OP_MOVE, S_P0 + 6'd2, S_P0 + 6'd2, S_INV);
         end
         default: uop = ar(OP_MOVE, S_ZERO, S_ZERO, S_ZERO);
      endcase
   end
endmodule

// File: rtl/ladder_fsm.sv
module ladder_fsm
   import ladder_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       done,
   input  logic       last_bit,
   output phase_e     phase,
   output logic [5:0] pc,
   output logic       load,
   output logic       step,
   output logic       req,
   output logic       busy,
   output logic       ready
);
   phase_e     ph_q;
   logic [5:0] pc_q;
   logic       adv;
   logic       pc_end;

   assign req  = (ph_q == PH_INIT) || (ph_q == PH_LOOP) || (ph_q == PH_FIN);
   assign adv  = req && done;
   assign load = (ph_q == PH_IDLE) && start;

   always_comb begin
      unique case (ph_q)
         PH_INIT: pc_end = (pc_q == 6'(INIT_LEN - 1));
         PH_LOOP: pc_end = (pc_q == 6'(LOOP_LEN - 1));
         PH_FIN:  pc_end = (pc_q == 6'(FIN_LEN - 1));
         default: pc_end = 1'b0;
      endcase
   end

   assign step = adv && (ph_q == PH_LOOP) && pc_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;
         pc_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start) begin
               ph_q <= PH_INIT;
               pc_q <= '0;
            end
            PH_INIT, PH_LOOP, PH_FIN: if (adv) begin
               if (pc_end) begin
                  pc_q <= '0;
                  if (ph_q == PH_INIT)      ph_q <= PH_LOOP;
                  else if (ph_q == PH_FIN)  ph_q <= PH_DONE;
                  else if (last_bit)        ph_q <= PH_FIN;
               end else begin
                  pc_q <= pc_q + 6'd1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = ph_q;
   assign pc    = pc_q;
   assign busy  = req;
   assign ready = (ph_q == PH_DONE);
endmodule

// File: rtl/ladder_seq.sv
module ladder_seq
   import ladder_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 8,
   parameter bit CLAMP_EN  = 1'b1,
   localparam int KEY_W = WORD_W * NUM_WORDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [KEY_W-1:0] scalar,
   output logic             busy,
   output logic             ready,
   output logic             uop_req,
   output logic [2:0]       uop_code,
   output logic [5:0]       uop_src_a,
   output logic [5:0]       uop_src_b,
   output logic [5:0]       uop_dst_a,
   output logic [5:0]       uop_dst_b,
   input  logic             uop_done
);
   phase_e     phase;
   logic [5:0] pc;
   logic       load, step, key_bit, last_bit;
   uop_t       uop;

   ladder_key #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CLAMP_EN(CLAMP_EN)) u_key (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .key_in(scalar), .key_bit(key_bit), .last_bit(last_bit)
   );

   ladder_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .done(uop_done),
      .last_bit(last_bit), .phase(phase), .pc(pc), .load(load),
      .step(step), .req(uop_req), .busy(busy), .ready(ready)
   );

   ladder_urom u_rom (.phase(phase), .pc(pc), .key_bit(key_bit), .uop(uop));

   assign uop_code  = uop.code;
   assign uop_src_a = uop.a;
   assign uop_src_b = uop.b;
   assign uop_dst_a = uop.d;
   assign uop_dst_b = uop.d2;
endmodule

// File: rtl/ladder_seq_chk.sv
module ladder_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       ready,
   input logic       uop_req,
   input logic [2:0] uop_code,
   input logic [5:0] uop_src_a,
   input logic [5:0] uop_src_b,
   input logic [5:0] uop_dst_a,
   input logic [5:0] uop_dst_b,
   input logic       uop_done
);
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_req && !uop_done) |=> (uop_req && $stable(uop_code) && $stable(uop_src_a)
         && $stable(uop_src_b) && $stable(uop_dst_a) && $stable(uop_dst_b)));

   p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !busy);

   p_req_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      uop_req |-> busy);

   p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_ready_after_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(uop_req && uop_done && uop_code == 3'd4));
endmodule

bind ladder_seq ladder_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ready(ready),
   .uop_req(uop_req), .uop_code(uop_code), .uop_src_a(uop_src_a),
   .uop_src_b(uop_src_b), .uop_dst_a(uop_dst_a), .uop_dst_b(uop_dst_b),
   .uop_done(uop_done)
);

// File: tb/tb_ladder_seq.sv
module tb_ladder_seq;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [255:0] scalar = '0;
   logic         busy, ready, uop_req, uop_done;
   logic [2:0]   uop_code;
   logic [5:0]   uop_src_a, uop_src_b, uop_dst_a, uop_dst_b;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   ladder_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
      .busy(busy), .ready(ready), .uop_req(uop_req), .uop_code(uop_code),
      .uop_src_a(uop_src_a), .uop_src_b(uop_src_b), .uop_dst_a(uop_dst_a),
      .uop_dst_b(uop_dst_b), .uop_done(uop_done)
   );

   // stub arithmetic engine: latency alternates between 1 and 2 cycles
   int stub_cnt = 0;
   int stub_n = 0;
   logic stub_done = 1'b0;
   assign uop_done = stub_done;
   always @(posedge clk) begin
      if (stub_done) begin
         stub_done <= 1'b0;
         stub_cnt  <= 0;
         stub_n    <= stub_n + 1;
      end else if (uop_req) begin
         if (stub_cnt + 1 >= 1 + (stub_n % 2)) stub_done <= 1'b1;
         else stub_cnt <= stub_cnt + 1;
      end
   end

   // reference model
   logic [26:0] exp_q[$];
   string       tag_q[$];
   logic        exp_busy = 1'b0;
   logic        exp_ready = 1'b0;
   logic        waiting = 1'b0;
   logic [26:0] wait_op;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [26:0] op(int c, int a, int b, int d, int d2);
      return {3'(c), 6'(a), 6'(b), 6'(d), 6'(d2)};
   endfunction

   task automatic put(int c, int a, int b, int d, int d2, string t);
      exp_q.push_back(op(c, a, b, d, d2));
      tag_q.push_back(t);
   endtask

   task automatic build(input logic [255:0] raw);
      logic [255:0] k;
      string t;
      int cb;
      k = raw;
      k[2:0] = 3'b000;   // R1
      k[255] = 1'b0;     // R2
      k[254] = 1'b1;
      put(0,0,0,5,5,"R4"); put(0,1,1,6,6,"R4"); put(0,1,1,7,7,"R4"); put(0,0,0,8,8,"R4");
      put(0,2,2,9,9,"R4"); put(0,3,3,10,10,"R4"); put(0,1,1,11,11,"R4"); put(0,4,4,12,12,"R4");
      for (int i = 0; i < 256; i++) begin
         t = (i < 3) ? "R1 R5" : (i >= 254) ? "R2 R5" : "R3 R5";
         for (int c = 0; c < 4; c++) put(0, 5+c, 5+c, (k[i] ? 21 : 25)+c, (k[i] ? 21 : 25)+c, t);
         for (int c = 0; c < 4; c++) put(0, 9+c, 9+c, (k[i] ? 25 : 21)+c, (k[i] ? 25 : 21)+c, t);
         // R6 doubling: A=29 B=30 C=31 D=32 E=33 F=34 G=35 H=36 I=37 J=38
         put(3,21,21,29,29,"R6"); put(3,22,22,30,30,"R6"); put(3,23,23,37,37,"R6");
         put(1,37,37,31,31,"R6"); put(1,21,22,37,37,"R6"); put(3,37,37,32,32,"R6");
         put(1,29,30,36,36,"R6"); put(2,36,32,33,33,"R6"); put(2,29,30,35,35,"R6");
         put(1,31,35,34,34,"R6"); put(3,33,34,13,13,"R6"); put(3,35,36,14,14,"R6");
         put(3,33,36,16,16,"R6"); put(3,34,35,15,15,"R6");
         // R6 addition
         put(2,14,13,37,37,"R6"); put(1,26,25,38,38,"R6"); put(3,37,38,29,29,"R6");
         put(1,14,13,37,37,"R6"); put(2,26,25,38,38,"R6"); put(3,37,38,30,30,"R6");
         put(3,15,28,37,37,"R6"); put(1,37,37,31,31,"R6"); put(3,16,27,37,37,"R6");
         put(1,37,37,32,32,"R6"); put(1,31,32,33,33,"R6"); put(2,30,29,34,34,"R6");
         put(1,30,29,35,35,"R6"); put(2,32,31,36,36,"R6"); put(3,33,34,17,17,"R6");
         put(3,35,36,18,18,"R6"); put(3,33,36,20,20,"R6"); put(3,34,35,19,19,"R6");
         cb = k[i] ? 5 : 9;
         put(0,17,18,cb,cb+1,"R3 R7"); put(0,19,20,cb+2,cb+3,"R3 R7");
      end
      put(0,7,7,39,39,"R8");
      put(4,39,39,39,39,"R8");
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check(busy == exp_busy, "R10", "busy", 64'(busy), 64'(exp_busy));
         check(ready == exp_ready, "R10", "ready", 64'(ready), 64'(exp_ready));
         if (waiting)
            check(uop_req && {uop_code,uop_src_a,uop_src_b,uop_dst_a,uop_dst_b} == wait_op,
                  "R9", "held request", 64'({uop_code,uop_src_a,uop_src_b,uop_dst_a,uop_dst_b}), 64'(wait_op));
         waiting = uop_req && !uop_done;
         wait_op = {uop_code,uop_src_a,uop_src_b,uop_dst_a,uop_dst_b};
         exp_ready = 1'b0;
         if (uop_req && uop_done) begin
            if (exp_q.size() == 0)
               check(1'b0, "R8", "extra operation", 64'(wait_op), 64'(0));
            else begin
               check(wait_op == exp_q[0], tag_q[0], "operation", 64'(wait_op), 64'(exp_q[0]));
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
            if (uop_code == 3'd4) begin
               exp_busy = 1'b0;
               exp_ready = 1'b1;
            end
         end
         if (start && !exp_busy && !ready) begin
            exp_busy = 1'b1;
            build(scalar);
         end
      end
   end

   task automatic run(input logic [255:0] k, input bit poke);
      @(posedge clk); #1;
      scalar = k;
      start  = 1'b1;
      @(posedge clk); #1;
      start  = 1'b0;
      if (poke) begin
         // R11: start with another scalar mid-run is ignored
         repeat (500) @(posedge clk);
         #1;
         scalar = ~k;
         start  = 1'b1;
         @(posedge clk); #1;
         start  = 1'b0;
      end
      while (!ready && cycles < 190000) @(posedge clk);
      repeat (3) @(posedge clk);
      #1;
      check(exp_q.size() == 0, "R3", "operations left", 64'(exp_q.size()), 64'(0));
      exp_q.delete();
      tag_q.delete();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !ready && !uop_req, "R10", "reset state",
            64'({busy, ready, uop_req}), 64'(0));
      run('0, 1'b0);
      run('1, 1'b1);
      run({8{32'hA5C3_0F96}}, 1'b0);
      if (cycles >= 190000) check(1'b0, "R10", "watchdog", 64'(cycles), 64'(0));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 195000);
      check(1'b0, "R10", "watchdog", 64'(cycles), 64'(0));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule